// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns an operand request into the data address that a load or store will use. Each request carries a mode code, two register operands (a base and an index), a 16-bit immediate and a 2-bit scale selector. For register- and immediate-based modes the address is formed in one pass through an adder tree. The indirect modes first read a pointer word from data memory and return that word as the address.

Requests use a valid/ready handshake. While the block is idle, `req_ready_o` is high and a request can be accepted on every clock. An indirect request sends a read to the memory port and drops ready until the read data comes back. Each result is a one-cycle pulse on `addr_valid_o` with the address on `addr_o`. All arithmetic wraps at the address width.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode code 0 (absolute): the result is the immediate, sign-extended from 16 to 32 bits.
- R2: Mode code 1 (register): the result is the base operand.
- R3: Mode code 2 (base plus offset): the result is the base plus the sign-extended immediate.
- R4: Mode code 3 (base plus index): the result is the base plus the index.
- R5: Mode code 4 (scaled): the result is the sign-extended immediate, plus the base, plus the index shifted left by the scale selector. Selector values 0 to 3 give factors of 1, 2, 4 and 8.
- R6: Mode codes 5 and 6 (indirect): the block reads memory at a pointer address and returns the word read as the result. The pointer address is the base for code 5 and the sign-extended immediate for code 6.
- R7: For a non-indirect request accepted on a clock edge, `addr_valid_o` is high for exactly the following cycle. A new request can be accepted on every edge while the block is idle.
- R8: After an indirect request is accepted, `req_ready_o` is low and `mem_req_o` is high, with `mem_addr_o` held at the pointer, until `mem_rvalid_i` is seen. The result is valid in the cycle after that edge, and ready returns to high in the same cycle.
- R9: Every addition wraps modulo 2^32, and there is no overflow indication.
- R10: While `rst_ni` is low, `req_ready_o` is high, and `addr_valid_o` and `mem_req_o` are low.
- R11: A request presented while the block is busy is not accepted, and it produces no result pulse. `mem_rvalid_i` seen while the block is idle produces no result.
- R12: Mode code 7 is reserved and behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted |
| mode_i | input | 3 | Addressing mode code |
| base_i | input | 32 | Base register operand |
| index_i | input | 32 | Index register operand |
| imm_i | input | 16 | Signed immediate |
| scale_i | input | 2 | Index shift amount (0..3) |
| mem_req_o | output | 1 | Pointer read pending |
| mem_addr_o | output | 32 | Pointer read address |
| mem_rdata_i | input | 32 | Pointer read data |
| mem_rvalid_i | input | 1 | Pointer read data valid |
| addr_valid_o | output | 1 | Result pulse |
| addr_o | output | 32 | Effective address |

## Verification
The direct modes and the reserved code are swept over every combination of six base values, six index values, five immediates and all four scales. The base and index values include zero, one, the signed extremes and all-ones. These operands separate sign extension from zero extension, a wrong shift amount from a wrong addend, and wrapped sums from saturated ones. The indirect modes are tried with read latencies of zero to three cycles, both with and without a competing request held during the wait. This separates early completion, pointer drift and accidental acceptance. Back-to-back requests and a read-data pulse arriving while the block is idle check that throughput is one request per cycle and that no spurious result appears.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    MODE_ABS     = 3'd0,
    MODE_REG     = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_BASEIDX = 3'd3,
    MODE_SCALED  = 3'd4,
    MODE_IND_REG = 3'd5,
    MODE_IND_IMM = 3'd6,
    MODE_RSVD    = 3'd7
  } eag_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } eag_state_e;
endpackage

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SCALE_W = 2
) (
  input  logic [2:0]         mode_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [ADDR_W-1:0]  ptr_o,
  output logic               indirect_o
);
  localparam int EXT_W = (ADDR_W > IMM_W) ? ADDR_W - IMM_W : 1;

  logic [ADDR_W-1:0] imm_x;
  logic [ADDR_W-1:0] idx_scaled;
  eag_mode_e         mode;

  generate
    if (ADDR_W > IMM_W) begin : g_sext
      assign imm_x = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_x = imm_i[ADDR_W-1:0];
    end
  endgenerate

  assign mode       = eag_mode_e'(mode_i);
  assign idx_scaled = index_i << scale_i;
  assign indirect_o = (mode == MODE_IND_REG) || (mode == MODE_IND_IMM);
  assign ptr_o      = (mode == MODE_IND_IMM) ? imm_x : base_i;

  always_comb begin
    unique case (mode)
      MODE_REG:     addr_o = base_i;
      MODE_DISP:    addr_o = base_i + imm_x;
      MODE_BASEIDX: addr_o = base_i + index_i;
      MODE_SCALED:  addr_o = imm_x + base_i + idx_scaled;
      default:      addr_o = imm_x; // absolute, reserved; unused for indirect
    endcase
  end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic indirect_i,
  input  logic mem_rvalid_i,
  output logic req_ready_o,
  output logic mem_req_o,
  output logic take_ptr_o,
  output logic fire_now_o,
  output logic fire_mem_o
);
  eag_state_e state_q, state_d;
  logic       accept;

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_WAIT);
  assign accept      = req_valid_i && req_ready_o;
  assign take_ptr_o  = accept && indirect_i;
  assign fire_now_o  = accept && !indirect_i;
  assign fire_mem_o  = mem_req_o && mem_rvalid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take_ptr_o) state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SCALE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [2:0]         mode_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  input  logic               mem_rvalid_i,
  output logic               addr_valid_o,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] calc_addr, calc_ptr;
  logic              calc_ind;
  logic              take_ptr, fire_now, fire_mem;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic              valid_q;

  eag_addr_calc #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .SCALE_W(SCALE_W)
  ) u_calc (
    .mode_i    (mode_i),
    .base_i    (base_i),
    .index_i   (index_i),
    .imm_i     (imm_i),
    .scale_i   (scale_i),
    .addr_o    (calc_addr),
    .ptr_o     (calc_ptr),
    .indirect_o(calc_ind)
  );

  eag_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .indirect_i  (calc_ind),
    .mem_rvalid_i(mem_rvalid_i),
    .req_ready_o (req_ready_o),
    .mem_req_o   (mem_req_o),
    .take_ptr_o  (take_ptr),
    .fire_now_o  (fire_now),
    .fire_mem_o  (fire_mem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      ptr_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire_now || fire_mem;
      if (fire_now)      addr_q <= calc_addr;
      else if (fire_mem) addr_q <= mem_rdata_i;
      if (take_ptr)      ptr_q  <= calc_ptr;
    end
  end

  assign addr_o       = addr_q;
  assign addr_valid_o = valid_q;
  assign mem_addr_o   = ptr_q;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SCALE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [2:0]         mode_i,
  input logic [ADDR_W-1:0]  base_i,
  input logic [ADDR_W-1:0]  index_i,
  input logic [IMM_W-1:0]   imm_i,
  input logic [SCALE_W-1:0] scale_i,
  input logic               mem_req_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [ADDR_W-1:0]  mem_rdata_i,
  input logic               mem_rvalid_i,
  input logic               addr_valid_o,
  input logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] imm_x;
  logic              acc;
  assign imm_x = ADDR_W'($signed(imm_i));
  assign acc   = req_valid_i && req_ready_o;

  assert_reset_idle_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (req_ready_o && !addr_valid_o && !mem_req_o));

  assert_abs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && mode_i == 3'd0) |=> (addr_valid_o && addr_o == $past(imm_x)));

  assert_disp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && mode_i == 3'd2) |=> (addr_valid_o && addr_o == $past(base_i + imm_x)));

  assert_baseidx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && mode_i == 3'd3) |=> (addr_o == $past(base_i + index_i)));

  assert_scaled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && mode_i == 3'd4) |=> (addr_o == $past(imm_x + base_i + (index_i << scale_i))));

  assert_ind_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (addr_valid_o && addr_o == $past(mem_rdata_i)));

  assert_busy_not_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_ptr_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_no_spurious_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> ($past(acc && mode_i != 3'd5 && mode_i != 3'd6) ||
                      $past(mem_req_o && mem_rvalid_i)));
endmodule

bind eff_addr_gen eag_checker #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .SCALE_W(SCALE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .mode_i(mode_i), .base_i(base_i),
  .index_i(index_i), .imm_i(imm_i), .scale_i(scale_i),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i),
  .addr_valid_o(addr_valid_o), .addr_o(addr_o)
);

// File: tb/tb_eff_addr_gen.sv
`timescale 1ns/1ps
module tb_eff_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  mode_i = '0;
  logic [31:0] base_i = '0, index_i = '0;
  logic [15:0] imm_i = '0;
  logic [1:0]  scale_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        addr_valid_o;
  logic [31:0] addr_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  eff_addr_gen dut (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  logic [31:0] reg_vals [6] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000,
                                32'hffff_ffff, 32'h1234_5678};
  logic [15:0] imm_vals [5] = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff};

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] expect_addr(input logic [2:0] m, input logic [31:0] b,
      input logic [31:0] x, input logic [15:0] im, input logic [1:0] sc);
    logic [31:0] f;
    f = 32'd1 << sc;
    case (m)
      3'd1:    return b;
      3'd2:    return b + sx(im);
      3'd3:    return b + x;
      3'd4:    return sx(im) + b + x * f;
      default: return sx(im);
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5a5a_c3c3;
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_direct(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
                            input logic [15:0] im, input logic [1:0] sc);
    mode_i = m; base_i = b; index_i = x; imm_i = im; scale_i = sc; req_valid_i = 1'b1;
    chk("R7 ready idle", {31'd0, req_ready_o}, 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R7 valid", {31'd0, addr_valid_o}, 32'd1);
    chk(mode_tag(m), addr_o, expect_addr(m, b, x, im, sc));
    @(negedge clk_i);
    chk("R7 pulse", {31'd0, addr_valid_o}, 32'd0);
  endtask

  task automatic run_ind(input logic [2:0] m, input logic [31:0] b, input logic [15:0] im,
                         input int lat, input bit hold);
    logic [31:0] ptr;
    ptr = (m == 3'd6) ? sx(im) : b;
    mode_i = m; base_i = b; imm_i = im; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = hold;
    if (hold) begin mode_i = 3'd0; imm_i = ~im; base_i = ~b; end
    chk("R8 ready low", {31'd0, req_ready_o}, 32'd0);
    chk("R8 mem_req", {31'd0, mem_req_o}, 32'd1);
    chk("R6 ptr addr", mem_addr_o, ptr);
    chk("R8 no early valid", {31'd0, addr_valid_o}, 32'd0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk_i);
      chk("R8 hold mem_req", {31'd0, mem_req_o}, 32'd1);
      chk("R8 ptr stable", mem_addr_o, ptr);
      chk("R11 busy no valid", {31'd0, addr_valid_o}, 32'd0);
    end
    mem_rvalid_i = 1'b1; mem_rdata_i = mem_word(ptr);
    @(negedge clk_i);
    mem_rvalid_i = 1'b0; req_valid_i = 1'b0; mem_rdata_i = 32'hdead_beef;
    chk("R6 valid", {31'd0, addr_valid_o}, 32'd1);
    chk("R6 data", addr_o, mem_word(ptr));
    chk("R8 ready back", {31'd0, req_ready_o}, 32'd1);
    chk("R8 mem_req drop", {31'd0, mem_req_o}, 32'd0);
    @(negedge clk_i);
    chk("R11 ignored request", {31'd0, addr_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 ready", {31'd0, req_ready_o}, 32'd1);
    chk("R10 valid", {31'd0, addr_valid_o}, 32'd0);
    chk("R10 mem_req", {31'd0, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1..R5, R12 sweep
    for (int m = 0; m < 8; m++) begin
      if (m == 5 || m == 6) continue;
      for (int bi = 0; bi < 6; bi++)
        for (int xi = 0; xi < 6; xi++)
          for (int ii = 0; ii < 5; ii++)
            for (int s = 0; s < 4; s++)
              run_direct(3'(m), reg_vals[bi], reg_vals[xi], imm_vals[ii], 2'(s));
    end

    // R9 wrap cases
    run_direct(3'd2, 32'hffff_ffff, 32'h0, 16'h0001, 2'd0);
    chk("R9 disp wrap", addr_o, 32'h0);
    run_direct(3'd4, 32'h0000_0000, 32'h2000_0000, 16'h0000, 2'd3);
    chk("R9 scaled wrap", addr_o, 32'h0);

    // R7 back-to-back
    mode_i = 3'd3; base_i = 32'h100; index_i = 32'h20; req_valid_i = 1'b1;
    @(negedge clk_i);
    mode_i = 3'd2; base_i = 32'h400; imm_i = 16'hfffc;
    chk("R7 b2b ready", {31'd0, req_ready_o}, 32'd1);
    chk("R7 b2b first", addr_o, 32'h120);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R7 b2b second valid", {31'd0, addr_valid_o}, 32'd1);
    chk("R7 b2b second", addr_o, 32'h3fc);
    @(negedge clk_i);

    // R6, R8, R11 indirect
    for (int m = 5; m <= 6; m++)
      for (int bi = 0; bi < 6; bi++)
        for (int ii = 0; ii < 5; ii++)
          for (int l = 0; l < 4; l++)
            run_ind(3'(m), reg_vals[bi], imm_vals[ii], l, (l % 2) == 1);

    // R11 stray read data while idle
    mem_rvalid_i = 1'b1; mem_rdata_i = 32'hcafe_f00d;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    chk("R11 stray rvalid", {31'd0, addr_valid_o}, 32'd0);
    chk("R11 stray mem_req", {31'd0, mem_req_o}, 32'd0);
    @(negedge clk_i);
    chk("R11 stray later", {31'd0, addr_valid_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule